// File: doc/BRIEF.md
# TDM Audio Frame Receiver

This block is the receiving end of a time-division-multiplexed serial audio link. The bit clock serves as its clock. On each rising edge it samples a frame-sync line and a serial data line. A rising transition of the sync line marks the start of a frame. The frame then holds a fixed number of equal-width slots, and each slot carries one channel. Every slot arrives most significant bit first. Its leading bits are a two's-complement audio word and the bits after them are padding.

After each slot the receiver presents the word in parallel, sign-extended to the output width, together with the channel index and a single-cycle valid strobe. Two things are set by the surrounding logic:

- Parameters fix the channel count, the slot width, the audio word width and the output width.
- An input selects where the first slot starts: on the same bit clock as the sync edge, or one bit clock later.

The receiver also polices the frame length. A sync edge that arrives too early, or that fails to arrive when a frame is complete, raises a sticky framing-error flag. The receiver then realigns on the next sync edge.

Top module: `tdm_frame_rx`

## Requirements
- R1: Only a low-to-high change of `fsync_i` between two consecutive clock samples starts a frame. The sync being high when reset releases is not a start. Falling edges have no effect on framing.
- R2: A sync pulse one clock wide and a sync pulse one slot wide produce identical output words, channels and error state.
- R3: With `delay_mode_i` = 0, bit 0 of slot 0 is the `sdata_i` value sampled on the same clock as the first high sample of `fsync_i`. With `delay_mode_i` = 1, it is the value sampled on the following clock.
- R4: Each slot is SLOT_BITS clocks long and received MSB first. Its first WORD_BITS bits form the word, and the remaining padding bits have no effect on any output.
- R5: `word_o` equals the received WORD_BITS word sign-extended to OUT_BITS.
- R6: `word_valid_o` is high for exactly one cycle, in the cycle after the last bit of each slot is sampled. At the same time `chan_o` holds the slot index, counting from 0 for the first slot of the frame. `word_o` and `chan_o` hold their values between strobes.
- R7: After reset, `word_valid_o` stays low and `frame_err_o` stays low until a sync rising edge has been seen, whatever `sdata_i` does.
- R8: A frame start that arrives before NUM_SLOTS slots have been completed sets `frame_err_o`. The unfinished slot produces no word, and the new frame starts at that edge. This holds even when the edge falls on the last bit of a slot.
- R9: If no frame start arrives on the clock right after the last slot of a frame, `frame_err_o` is set and no words are output until the next sync rising edge.
- R10: `frame_err_o` is 0 after reset and, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync_i | input | 1 | Frame sync; its rising edge marks a frame start |
| sdata_i | input | 1 | Serial audio data |
| delay_mode_i | input | 1 | 0: first slot starts on the sync edge clock; 1: one clock later |
| word_o | output | OUT_BITS | Last received word, sign-extended |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| chan_o | output | clog2(NUM_SLOTS) | Slot index of the word on `word_o` |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
Two things can land on the same clock: the completion of a slot and a frame start. In the legal case, the delayed-alignment sync edge coincides with the last bit of the previous frame. This must not disturb that frame's final word. In the illegal case, a new sync edge lands exactly on the last bit of a slot mid-frame. Here the restart must win: that slot's word is dropped and the error flag rises. The bench provokes both. It streams back-to-back frames in delayed mode, and it cuts a frame off after SLOT_BITS-1 bits before restarting. A behavioural queue model, compared on every clock, then judges the strobes, words and error flag.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Placement of slot 0 relative to the sync rising edge.
  typedef enum logic {
    ALIGN_SAME = 1'b0,
    ALIGN_LATE = 1'b1
  } align_e;

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/tdm_sync_edge.sv
module tdm_sync_edge
  import tdm_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  input  logic delay_mode_i,
  output logic start_o
);

  logic fs_q;
  logic fs_d;
  logic rise_q;
  logic rise_d;
  logic rise_now;

  always_comb begin
    rise_now = fsync_i & ~fs_q;
    fs_d     = fsync_i;
    rise_d   = rise_now;
    // Late alignment reuses the registered edge: slot 0 begins one clock on.
    start_o  = (align_e'(delay_mode_i) == ALIGN_LATE) ? rise_q : rise_now;
  end

  // Previous sync sample resets high so a sync already high is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      rise_q <= rise_d;
    end
  end

endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_rx_pkg::*;
#(
  parameter  int NUM_SLOTS = 6,
  parameter  int SLOT_BITS = 32,
  localparam int BIT_W     = idx_width(SLOT_BITS),
  localparam int SLOT_W    = idx_width(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              in_frame_o,
  output logic [BIT_W-1:0]  bit_pos_o,
  output logic [SLOT_W-1:0] slot_pos_o,
  output logic              slot_end_o,
  output logic              frame_err_o
);

  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic              lock_q, lock_d;
  logic              wrap_q, wrap_d;
  logic              err_q, err_d;
  logic [BIT_W-1:0]  bit_q, bit_d, cur_bit;
  logic [SLOT_W-1:0] slot_q, slot_d, cur_slot;
  logic              early, missing, frame_end;

  always_comb begin
    // wrap_q marks the one clock where a frame start is due.
    early      = start_i & lock_q & ~wrap_q;
    missing    = ~start_i & lock_q & wrap_q;
    in_frame_o = start_i | (lock_q & ~wrap_q);
    cur_bit    = start_i ? '0 : bit_q;
    cur_slot   = start_i ? '0 : slot_q;
    slot_end_o = in_frame_o & (cur_bit == LAST_BIT);
    frame_end  = slot_end_o & (cur_slot == LAST_SLOT);

    lock_d = in_frame_o;
    wrap_d = frame_end;
    bit_d  = bit_q;
    slot_d = slot_q;
    if (in_frame_o) begin
      bit_d  = slot_end_o ? '0 : cur_bit + BIT_W'(1);
      slot_d = frame_end ? '0 : (slot_end_o ? cur_slot + SLOT_W'(1) : cur_slot);
    end
    err_d = err_q | early | missing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      wrap_q <= 1'b0;
      err_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      lock_q <= lock_d;
      wrap_q <= wrap_d;
      err_q  <= err_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign bit_pos_o   = cur_bit;
  assign slot_pos_o  = cur_slot;
  assign frame_err_o = err_q;

endmodule

// File: rtl/tdm_word_assembler.sv
module tdm_word_assembler
  import tdm_rx_pkg::*;
#(
  parameter  int NUM_SLOTS = 6,
  parameter  int SLOT_BITS = 32,
  parameter  int WORD_BITS = 24,
  parameter  int OUT_BITS  = 32,
  localparam int BIT_W     = idx_width(SLOT_BITS),
  localparam int SLOT_W    = idx_width(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdata_i,
  input  logic                in_frame_i,
  input  logic [BIT_W-1:0]    bit_pos_i,
  input  logic [SLOT_W-1:0]   slot_pos_i,
  input  logic                slot_end_i,
  output logic [OUT_BITS-1:0] word_o,
  output logic                valid_o,
  output logic [SLOT_W-1:0]   chan_o
);

  localparam logic [BIT_W:0] WORD_LIM = (BIT_W + 1)'(WORD_BITS);

  logic [WORD_BITS-1:0]        sh_q, sh_d;
  logic signed [WORD_BITS-1:0] sh_s;
  logic [OUT_BITS-1:0]         word_q, word_d;
  logic                        valid_q, valid_d;
  logic [SLOT_W-1:0]           chan_q, chan_d;
  logic                        take;

  always_comb begin
    // Only the word bits enter the shifter; padding leaves it untouched.
    take    = in_frame_i & ({1'b0, bit_pos_i} < WORD_LIM);
    sh_d    = take ? {sh_q[WORD_BITS-2:0], sdata_i} : sh_q;
    sh_s    = sh_d;
    valid_d = slot_end_i;
    word_d  = slot_end_i ? OUT_BITS'(sh_s) : word_q;
    chan_d  = slot_end_i ? slot_pos_i : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      chan_q  <= chan_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign chan_o  = chan_q;

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter  int NUM_SLOTS = 6,
  parameter  int SLOT_BITS = 32,
  parameter  int WORD_BITS = 24,
  parameter  int OUT_BITS  = 32,
  localparam int CHAN_W    = idx_width(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync_i,
  input  logic                sdata_i,
  input  logic                delay_mode_i,
  output logic [OUT_BITS-1:0] word_o,
  output logic                word_valid_o,
  output logic [CHAN_W-1:0]   chan_o,
  output logic                frame_err_o
);

  localparam int BIT_W = idx_width(SLOT_BITS);

  logic              srst_n;
  logic              start;
  logic              in_frame;
  logic [BIT_W-1:0]  bit_pos;
  logic [CHAN_W-1:0] slot_pos;
  logic              slot_end;

  tdm_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tdm_sync_edge u_edge (
    .clk          (clk),
    .rst_n        (srst_n),
    .fsync_i      (fsync_i),
    .delay_mode_i (delay_mode_i),
    .start_o      (start)
  );

  tdm_slot_tracker #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BITS (SLOT_BITS)
  ) u_track (
    .clk         (clk),
    .rst_n       (srst_n),
    .start_i     (start),
    .in_frame_o  (in_frame),
    .bit_pos_o   (bit_pos),
    .slot_pos_o  (slot_pos),
    .slot_end_o  (slot_end),
    .frame_err_o (frame_err_o)
  );

  tdm_word_assembler #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .WORD_BITS (WORD_BITS),
    .OUT_BITS  (OUT_BITS)
  ) u_asm (
    .clk        (clk),
    .rst_n      (srst_n),
    .sdata_i    (sdata_i),
    .in_frame_i (in_frame),
    .bit_pos_i  (bit_pos),
    .slot_pos_i (slot_pos),
    .slot_end_i (slot_end),
    .word_o     (word_o),
    .valid_o    (word_valid_o),
    .chan_o     (chan_o)
  );

endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker
  import tdm_rx_pkg::*;
#(
  parameter  int NUM_SLOTS = 6,
  parameter  int WORD_BITS = 24,
  parameter  int OUT_BITS  = 32,
  localparam int CHAN_W    = idx_width(NUM_SLOTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fsync_i,
  input logic [OUT_BITS-1:0] word_o,
  input logic                word_valid_o,
  input logic [CHAN_W-1:0]   chan_o,
  input logic                frame_err_o
);

  logic fs_prev_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b1;
      seen_q    <= 1'b0;
    end else begin
      fs_prev_q <= fsync_i;
      seen_q    <= seen_q | (fsync_i & ~fs_prev_q);
    end
  end

  // R7
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!word_valid_o && !frame_err_o));

  // R6
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (int'(chan_o) < NUM_SLOTS));

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> ($stable(word_o) && $stable(chan_o)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);

  // R5
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> ((&word_o[OUT_BITS-1:WORD_BITS-1]) || !(|word_o[OUT_BITS-1:WORD_BITS-1])));

endmodule

bind tdm_frame_rx tdm_rx_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .WORD_BITS (WORD_BITS),
  .OUT_BITS  (OUT_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (srst_n),
  .fsync_i      (fsync_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .chan_o       (chan_o),
  .frame_err_o  (frame_err_o)
);

// File: tb/tb_tdm_frame_rx.sv
`timescale 1ns/1ps
module tb_tdm_frame_rx;

  localparam int NS = 4;
  localparam int SB = 32;
  localparam int WB = 24;
  localparam int OB = 32;
  localparam int FB = NS * SB;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic fsync = 1'b0;
  logic sdata = 1'b0;
  logic dly = 1'b0;
  logic [OB-1:0] word;
  logic          valid;
  logic [CW-1:0] chan;
  logic          ferr;

  int compared = 0;
  int mismatched = 0;
  bit run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  tdm_frame_rx #(
    .NUM_SLOTS (NS),
    .SLOT_BITS (SB),
    .WORD_BITS (WB),
    .OUT_BITS  (OB)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fsync_i      (fsync),
    .sdata_i      (sdata),
    .delay_mode_i (dly),
    .word_o       (word),
    .word_valid_o (valid),
    .chan_o       (chan),
    .frame_err_o  (ferr)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_prev_fs, m_prev_rise, m_lock, m_wrap, m_err, m_valid;
  int m_bit, m_slot, m_chan;
  logic [OB-1:0] m_word;
  bit bitq[$];

  function automatic void model_step(bit fs, bit sd, bit dl);
    bit rise, start, infr;
    logic [WB-1:0] w;
    rise = fs && !m_prev_fs;
    m_prev_fs = fs;
    start = dl ? m_prev_rise : rise;
    m_prev_rise = rise;
    m_valid = 1'b0;
    infr = 1'b0;
    if (start) begin
      if (m_lock && !m_wrap) m_err = 1'b1;
      m_lock = 1'b1; m_bit = 0; m_slot = 0; bitq.delete(); infr = 1'b1;
    end else if (m_lock && m_wrap) begin
      m_err = 1'b1; m_lock = 1'b0;
    end else begin
      infr = m_lock;
    end
    m_wrap = 1'b0;
    if (infr) begin
      bitq.push_back(sd);
      if (m_bit == SB - 1) begin
        for (int i = 0; i < WB; i++) w[WB-1-i] = bitq[i];
        m_word = {{(OB-WB){w[WB-1]}}, w};
        m_chan = m_slot;
        m_valid = 1'b1;
        bitq.delete();
        m_bit = 0;
        if (m_slot == NS - 1) begin m_slot = 0; m_wrap = 1'b1; end
        else m_slot++;
      end else begin
        m_bit++;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_fs = 1'b1; m_prev_rise = 1'b0; m_lock = 1'b0; m_wrap = 1'b0;
      m_err = 1'b0; m_valid = 1'b0; m_bit = 0; m_slot = 0; m_chan = 0;
      m_word = '0; bitq.delete();
    end else begin
      model_step(fsync, sdata, dly);
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (run_cmp) begin
      check(valid === m_valid, "R6 strobe", 64'(valid), 64'(m_valid));
      check(chan === CW'(m_chan), "R6 channel", 64'(chan), 64'(m_chan));
      check(word === m_word, "R4 word", 64'(word), 64'(m_word));
      check(ferr === m_err, "R8/R9 error flag", 64'(ferr), 64'(m_err));
    end
  end

  logic [OB-1:0] got_w[$];
  logic [CW-1:0] got_c[$];
  always @(negedge clk) begin
    if (run_cmp && valid === 1'b1) begin
      got_w.push_back(word);
      got_c.push_back(chan);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [WB-1:0] sample_val(int f, int s, int seed);
    int x;
    logic [WB-1:0] v;
    x = seed * 40503 + f * 4099 + s * 1234567 + 17;
    v = WB'(x);
    v[WB-1] = s[0];
    return v;
  endfunction

  function automatic logic [OB-1:0] sext(logic [WB-1:0] v);
    return {{(OB-WB){v[WB-1]}}, v};
  endfunction

  task automatic do_reset(bit fs_level);
    @(negedge clk);
    #1;
    rst_n = 1'b0; fsync = fs_level; sdata = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1'b1;
    run_cmp = 1'b1;
    repeat (4) @(negedge clk);
    got_w.delete();
    got_c.delete();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fsync = 1'b0; sdata = 1'b0;
    end
  endtask

  // Streams nf frames; pad bits are driven high to show they are ignored.
  task automatic run_stream(bit dl, bit wide, int nf, int seed, int maxc);
    int total;
    total = nf * FB + int'(dl);
    if (maxc >= 0 && maxc < total) total = maxc;
    for (int c = 0; c < total; c++) begin
      int d, f, s, b;
      logic [WB-1:0] v;
      @(negedge clk);
      dly = dl;
      fsync = (c < nf * FB) && ((c % FB) < (wide ? SB : 1));
      d = c - int'(dl);
      if (d >= 0 && d < nf * FB) begin
        f = d / FB; s = (d % FB) / SB; b = d % SB;
        v = sample_val(f, s, seed);
        sdata = (b < WB) ? v[WB-1-b] : 1'b1;
      end else begin
        sdata = 1'b0;
      end
    end
  endtask

  task automatic verify_frames(int nf, int seed, string req);
    check(got_w.size() == nf * NS, req, 64'(got_w.size()), 64'(nf * NS));
    for (int f = 0; f < nf; f++) begin
      for (int s = 0; s < NS; s++) begin
        int idx;
        logic [OB-1:0] e;
        idx = f * NS + s;
        e = sext(sample_val(f, s, seed));
        if (idx < got_w.size()) begin
          check(got_w[idx] === e, req, 64'(got_w[idx]), 64'(e));
          check(got_c[idx] === CW'(s), req, 64'(got_c[idx]), 64'(s));
        end
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (R6): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // Reset state and no output before any sync (R7, R10)
    do_reset(1'b0);
    check(valid === 1'b0 && ferr === 1'b0 && word === '0, "R10 reset state",
          {valid, ferr, word}, 64'd0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      fsync = 1'b0; sdata = i[0] ^ i[3];
    end
    check(got_w.size() == 0, "R7 no words before sync", 64'(got_w.size()), 0);
    check(ferr === 1'b0, "R7 no error before sync", 64'(ferr), 0);

    // Aligned mode, one-clock sync; then the missing sync after the stream (R3, R9)
    do_reset(1'b0);
    run_stream(1'b0, 1'b0, 3, 1, -1);
    check(ferr === 1'b0, "R8 clean frames raise no error", 64'(ferr), 0);
    idle(4);
    verify_frames(3, 1, "R3 aligned");
    check(ferr === 1'b1, "R9 missing sync flagged", 64'(ferr), 1);
    idle(300);
    check(got_w.size() == 3 * NS, "R9 no words after lost lock", 64'(got_w.size()), 64'(3 * NS));

    // Aligned mode, slot-wide sync (R2)
    do_reset(1'b0);
    run_stream(1'b0, 1'b1, 2, 1, -1);
    check(ferr === 1'b0, "R2 wide sync no error", 64'(ferr), 0);
    idle(4);
    verify_frames(2, 1, "R2 wide sync");

    // Delayed mode with both sync widths (R3, R5)
    do_reset(1'b0);
    run_stream(1'b1, 1'b0, 2, 3, -1);
    check(ferr === 1'b0, "R3 delayed no error", 64'(ferr), 0);
    idle(4);
    verify_frames(2, 3, "R3 delayed");
    do_reset(1'b0);
    run_stream(1'b1, 1'b1, 2, 4, -1);
    idle(4);
    verify_frames(2, 4, "R5 sign extension");

    // Early sync in the middle of slot 1 (R8)
    do_reset(1'b0);
    run_stream(1'b0, 1'b0, 1, 5, SB + 10);
    run_stream(1'b0, 1'b0, 2, 6, -1);
    check(ferr === 1'b1, "R8 early sync flagged", 64'(ferr), 1);
    idle(4);
    check(got_w.size() == 1 + 2 * NS, "R8 partial slot dropped", 64'(got_w.size()), 64'(1 + 2 * NS));
    if (got_w.size() > 1) begin
      check(got_w[0] === sext(sample_val(0, 0, 5)), "R8 word before restart", 64'(got_w[0]),
            64'(sext(sample_val(0, 0, 5))));
      check(got_w[1] === sext(sample_val(0, 0, 6)), "R8 word after restart", 64'(got_w[1]),
            64'(sext(sample_val(0, 0, 6))));
    end

    // Early sync on the last bit of a slot (R8)
    do_reset(1'b0);
    run_stream(1'b0, 1'b0, 1, 7, SB - 1);
    run_stream(1'b0, 1'b0, 1, 8, -1);
    check(ferr === 1'b1, "R8 coincident restart flagged", 64'(ferr), 1);
    idle(4);
    verify_frames(1, 8, "R8 coincident restart");

    // Reset clears the sticky flag (R10)
    do_reset(1'b0);
    check(ferr === 1'b0, "R10 flag cleared by reset", 64'(ferr), 0);

    // Sync already high at reset release is not a frame start (R1)
    do_reset(1'b1);
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      fsync = 1'b1; sdata = i[1];
    end
    idle(20);
    check(got_w.size() == 0, "R1 high at release ignored", 64'(got_w.size()), 0);
    check(ferr === 1'b0, "R1 no error without edge", 64'(ferr), 0);

    idle(4);
    summary();
    $finish;
  end

endmodule